// File: doc/BRIEF.md
# Surprise-Down Error Qualifier

This block sits beside the link controller of a downstream switch port. It watches the port's link-up status and decides whether a transition from active to down is a surprise. A loss that some higher layer or a local control caused on purpose is not an error. Only the other losses are recorded as a surprise-down uncorrectable error.

There are nine exemption causes, carried on one vector, and each has its own "expected-down" flag. When a cause is seen, its flag arms a programmable window. Any link drop inside that window is exempt. The flag clears when the window runs out while the link is still up, or when the link comes back to active.

A qualified drop sets a sticky status bit, which software clears by writing one. It also sends a single-cycle report pulse, with its severity, toward an error-message generator, unless the error is masked.

Top module: `sdq_surprise_down_qual`

## Requirements
- R1: A link drop sets `status_o` on the clock edge that ends the cycle in which the drop is seen, provided no exemption covers it. A link drop is a cycle in which `link_up_i` is 0 after being 1 in the previous cycle. A rising edge of the link, or a link that stays down, never sets the status.
- R2: Causes from the hot-reset group exempt a drop. Bit 0 of `exempt_i` is hot-reset training sets received upstream, bit 1 is upstream link down, bit 2 is an upstream secondary bus reset and bit 3 is a downstream secondary bus reset.
- R3: Bit 4 of `exempt_i` (owning partition disabled) and bit 5 (port disabled) each exempt a drop.
- R4: Bit 6 of `exempt_i` (full retrain after an operating-mode change), bit 7 (full retrain by the software control) and bit 8 (clocking-mode change) each exempt a drop.
- R5: A cause seen in cycle t covers drops in cycles t through t+`win_i`. A drop in cycle t+`win_i`+1, with no new cause in between, is logged. When `win_i` is 0, only a drop in cycle t itself is exempt.
- R6: Once a flag has been armed and the link has dropped, the flag stays set while the link is down. It clears when the link comes back up, so the next unexempted drop is logged.
- R7: `status_o` is sticky and is cleared only by `clr_i`, taking effect on the next edge. If a set and a clear arrive in the same cycle, the set wins.
- R8: `rpt_o` is high for exactly one cycle, namely the cycle in which `status_o` first reads 1 after being 0. It is raised only if `mask_i` was 0 in the cycle the drop was seen. No pulse is raised if the status was already set.
- R9: `rpt_sev_o` equals the `sev_i` value sampled together with the reporting drop while `rpt_o` is high, and is 0 at all other times.
- R10: Reset (`rst_ni` low) forces `status_o`, `rpt_o`, `rpt_sev_o` and every exemption flag to 0. The link history is also cleared, so a link that is already up when reset ends is not seen as a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Data-link active status |
| exempt_i | input | 9 | Intentional-loss causes, one bit per source (see R2 to R4) |
| win_i | input | WIN_W | Exemption window length in cycles |
| clr_i | input | 1 | Write-one-to-clear strobe for the status |
| mask_i | input | 1 | Error mask; when high, no report pulse is sent |
| sev_i | input | 1 | Severity of the error (1 = fatal) |
| status_o | output | 1 | Sticky surprise-down status |
| rpt_o | output | 1 | One-cycle error report pulse |
| rpt_sev_o | output | 1 | Severity attached to the report pulse |

## Verification
The assertions check the following on every cycle:
- the status rises only after an unexempted drop;
- the status holds until it is cleared, and the set wins against a clear;
- any active cause blocks the qualified event;
- a report pulse appears only on a status rise with the mask low;
- the severity output is never high without a report;
- the flags are released when the link returns.

The precise width of the exemption window, including the boundary cycle t+`win_i`+1 and the degenerate zero-length window, needs the bench's timed scenarios. The same holds for the separate effect of each of the nine cause bits and for the reset behaviour.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam int unsigned N_SRC = 9;

  // Bit positions of the exemption causes (R2, R3, R4)
  localparam int unsigned SRC_HR_TS      = 0;
  localparam int unsigned SRC_UP_DOWN    = 1;
  localparam int unsigned SRC_UP_SBR     = 2;
  localparam int unsigned SRC_DN_SBR     = 3;
  localparam int unsigned SRC_PART_DIS   = 4;
  localparam int unsigned SRC_PORT_DIS   = 5;
  localparam int unsigned SRC_MODE_RTRN  = 6;
  localparam int unsigned SRC_SW_RTRN    = 7;
  localparam int unsigned SRC_CLK_MODE   = 8;

  // Sticky status update: a set wins against a clear
  function automatic logic sts_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // A report is sent only on a 0-to-1 status change with the mask low
  function automatic logic rpt_fire(input logic cur, input logic set, input logic mask);
    return set & ~cur & ~mask;
  endfunction
endpackage

// File: rtl/sdq_link_edge.sv
module sdq_link_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_up_i,
  output logic fall_o,
  output logic rise_o
);
  logic link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_q <= 1'b0;
    else         link_q <= link_up_i;
  end

  assign fall_o = link_q & ~link_up_i;
  assign rise_o = ~link_q & link_up_i;
endmodule

// File: rtl/sdq_exempt_slot.sv
module sdq_exempt_slot #(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cause_i,
  input  logic             link_up_i,
  input  logic             rise_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             flag_o,
  output logic             cover_o
);
  logic             flag_q;
  logic [WIN_W-1:0] cnt_q;

  // A slot covers a drop in the cycle of its cause or while its count is nonzero
  function automatic logic slot_covers(input logic cause, input logic flag,
                                       input logic [WIN_W-1:0] cnt);
    return cause | (flag & (cnt != '0));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cause_i) begin
      flag_q <= 1'b1;
      cnt_q  <= win_i;
    end else if (flag_q) begin
      if (rise_i) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else if (link_up_i) begin
        if (cnt_q == '0) flag_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
      // link down: hold the flag until the link returns
    end
  end

  assign flag_o  = flag_q;
  assign cover_o = slot_covers(cause_i, flag_q, cnt_q);
endmodule

// File: rtl/sdq_status.sv
module sdq_status
  import sdq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  input  logic sev_i,
  output logic status_o,
  output logic rpt_o,
  output logic rpt_sev_o
);
  logic sts_q, rpt_q, sev_q;
  logic fire_w;

  assign fire_w = rpt_fire(sts_q, set_i, mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
      rpt_q <= 1'b0;
      sev_q <= 1'b0;
    end else begin
      sts_q <= sts_next(sts_q, set_i, clr_i);
      rpt_q <= fire_w;
      sev_q <= fire_w & sev_i;
    end
  end

  assign status_o  = sts_q;
  assign rpt_o     = rpt_q;
  assign rpt_sev_o = sev_q;
endmodule

// File: rtl/sdq_surprise_down_qual.sv
module sdq_surprise_down_qual
  import sdq_pkg::*;
#(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_up_i,
  input  logic [N_SRC-1:0] exempt_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             clr_i,
  input  logic             mask_i,
  input  logic             sev_i,
  output logic             status_o,
  output logic             rpt_o,
  output logic             rpt_sev_o
);
  // Named internal events, used by the checker
  logic             fall_w;
  logic             rise_w;
  logic [N_SRC-1:0] flag_w;
  logic [N_SRC-1:0] cover_w;
  logic             exempt_any_w;
  logic             sd_evt_w;

  sdq_link_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_up_i (link_up_i),
    .fall_o    (fall_w),
    .rise_o    (rise_w)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    sdq_exempt_slot #(.WIN_W(WIN_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cause_i   (exempt_i[g]),
      .link_up_i (link_up_i),
      .rise_i    (rise_w),
      .win_i     (win_i),
      .flag_o    (flag_w[g]),
      .cover_o   (cover_w[g])
    );
  end

  assign exempt_any_w = |cover_w;
  assign sd_evt_w     = fall_w & ~exempt_any_w;

  sdq_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (sd_evt_w),
    .clr_i     (clr_i),
    .mask_i    (mask_i),
    .sev_i     (sev_i),
    .status_o  (status_o),
    .rpt_o     (rpt_o),
    .rpt_sev_o (rpt_sev_o)
  );
endmodule

// File: rtl/sdq_checker.sv
module sdq_checker
  import sdq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] exempt_i,
  input logic             clr_i,
  input logic             mask_i,
  input logic             status_o,
  input logic             rpt_o,
  input logic             rpt_sev_o,
  input logic             fall_w,
  input logic             rise_w,
  input logic [N_SRC-1:0] flag_w,
  input logic             sd_evt_w
);
  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_evt_w |=> status_o); // R1
  AST_EVT_NEEDS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_evt_w |-> fall_w); // R1
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(sd_evt_w)); // R1
  AST_CAUSE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_w && (|exempt_i)) |-> !sd_evt_w); // R2
  AST_FLAG_DROP_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_w && !(|exempt_i)) |=> (flag_w == '0)); // R6
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_i) |=> status_o); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && clr_i && !sd_evt_w) |=> !status_o); // R7
  AST_RPT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_o |-> $rose(status_o)); // R8
  AST_RPT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_o |-> !$past(mask_i)); // R8
  AST_SEV_WITH_RPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_sev_o |-> rpt_o); // R9
endmodule

bind sdq_surprise_down_qual sdq_checker chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .exempt_i  (exempt_i),
  .clr_i     (clr_i),
  .mask_i    (mask_i),
  .status_o  (status_o),
  .rpt_o     (rpt_o),
  .rpt_sev_o (rpt_sev_o),
  .fall_w    (fall_w),
  .rise_w    (rise_w),
  .flag_w    (flag_w),
  .sd_evt_w  (sd_evt_w)
);

// File: tb/sdq_surprise_down_qual_tb_top.sv
module sdq_surprise_down_qual_tb_top;
  localparam int unsigned WIN_W = 8;
  localparam int unsigned NV    = 26;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             link_up_i = 1'b0;
  logic [8:0]       exempt_i = '0;
  logic [WIN_W-1:0] win_i = 8'd3;
  logic             clr_i = 1'b0, mask_i = 1'b0, sev_i = 1'b0;
  logic             status_o, rpt_o, rpt_sev_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  sdq_surprise_down_qual #(.WIN_W(WIN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .link_up_i(link_up_i), .exempt_i(exempt_i),
    .win_i(win_i), .clr_i(clr_i), .mask_i(mask_i), .sev_i(sev_i),
    .status_o(status_o), .rpt_o(rpt_o), .rpt_sev_o(rpt_sev_o)
  );

  // {link, exempt[8:0], clr, mask, sev, exp_status, exp_rpt, exp_sev}, window = 3
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 9'h000, 3'b000, 3'b000},  // 0
    {1'b1, 9'h000, 3'b000, 3'b000},  // 1
    {1'b0, 9'h000, 3'b001, 3'b111},  // 2  unexempted drop, fatal
    {1'b0, 9'h000, 3'b000, 3'b100},  // 3  sticky
    {1'b0, 9'h000, 3'b100, 3'b000},  // 4  clear
    {1'b1, 9'h000, 3'b000, 3'b000},  // 5
    {1'b0, 9'h001, 3'b000, 3'b000},  // 6  drop with cause in same cycle
    {1'b1, 9'h000, 3'b000, 3'b000},  // 7  rise releases flag
    {1'b1, 9'h010, 3'b000, 3'b000},  // 8  cause at t
    {1'b1, 9'h000, 3'b000, 3'b000},  // 9
    {1'b1, 9'h000, 3'b000, 3'b000},  // 10
    {1'b0, 9'h000, 3'b000, 3'b000},  // 11 drop at t+3: exempt
    {1'b1, 9'h000, 3'b000, 3'b000},  // 12 rise releases flag
    {1'b0, 9'h000, 3'b010, 3'b100},  // 13 drop logged, masked
    {1'b0, 9'h000, 3'b100, 3'b000},  // 14 clear
    {1'b1, 9'h000, 3'b000, 3'b000},  // 15
    {1'b1, 9'h080, 3'b000, 3'b000},  // 16 cause at t
    {1'b1, 9'h000, 3'b000, 3'b000},  // 17
    {1'b1, 9'h000, 3'b000, 3'b000},  // 18
    {1'b1, 9'h000, 3'b000, 3'b000},  // 19
    {1'b0, 9'h000, 3'b000, 3'b110},  // 20 drop at t+4: logged
    {1'b1, 9'h000, 3'b100, 3'b000},  // 21 clear
    {1'b0, 9'h000, 3'b001, 3'b111},  // 22 drop, fatal report
    {1'b1, 9'h000, 3'b000, 3'b100},  // 23
    {1'b0, 9'h000, 3'b100, 3'b100},  // 24 set and clear together: set wins
    {1'b0, 9'h000, 3'b100, 3'b000}   // 25 clear
  };

  function automatic string row_tag(input int r);
    case (r)
      2:       return "R1/R8";
      3, 4:    return "R7";
      6:       return "R2";
      11, 20:  return "R5";
      13:      return "R6";
      22:      return "R9";
      24:      return "R7";
      default: return "R1";
    endcase
  endfunction

  function automatic string bit_tag(input int b);
    if (b < 4)      return "R2";
    else if (b < 6) return "R3";
    else            return "R4";
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are read one full cycle later
  task automatic step(input logic lk, input logic [8:0] ex, input logic c, input logic m, input logic s);
    link_up_i = lk; exempt_i = ex; clr_i = c; mask_i = m; sev_i = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R10: reset state while link already up
    link_up_i = 1'b1;
    @(negedge clk);
    chk("R10", "status in reset", status_o, 1'b0);
    chk("R10", "rpt in reset", rpt_o, 1'b0);
    rst_ni = 1'b1;
    step(1'b1, '0, 1'b0, 1'b0, 1'b0);
    chk("R10", "no drop seen after reset", status_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      step(v[15], v[14:6], v[5], v[4], v[3]);
      chk(row_tag(i), $sformatf("row %0d status", i), status_o, v[2]);
      chk(row_tag(i), $sformatf("row %0d rpt", i), rpt_o, v[1]);
      chk(row_tag(i), $sformatf("row %0d rpt_sev", i), rpt_sev_o, v[0]);
    end

    // R2/R3/R4: each cause bit alone, drop one cycle after the cause
    for (int b = 0; b < 9; b++) begin
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 9'(1) << b, 1'b0, 1'b0, 1'b0);
      step(1'b0, '0, 1'b0, 1'b0, 1'b0);
      chk(bit_tag(b), $sformatf("cause bit %0d exempts drop", b), status_o, 1'b0);
      chk(bit_tag(b), $sformatf("cause bit %0d no report", b), rpt_o, 1'b0);
    end

    // R5: zero-length window
    win_i = '0;
    step(1'b1, '0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 9'h020, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk("R5", "zero window, drop at t+1 logged", status_o, 1'b1);
    chk("R8", "zero window report", rpt_o, 1'b1);
    step(1'b1, '0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 9'h020, 1'b0, 1'b0, 1'b0);
    chk("R5", "zero window, drop at t exempt", status_o, 1'b0);

    // R8: drop while status already set gives no second report
    win_i = 8'd3;
    step(1'b1, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    step(1'b1, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    chk("R8", "no report when already set", rpt_o, 1'b0);
    chk("R7", "status still set", status_o, 1'b1);

    // R10: reset in mid-run clears a set status
    rst_ni = 1'b0;
    #1;
    chk("R10", "status cleared by reset", status_o, 1'b0);
    chk("R10", "rpt cleared by reset", rpt_o, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule